// File: doc/BRIEF.md
# Split-Phase Data Clock Recovery

This block takes a split-phase serial line and sampled on a fast system clock. It recovers a bit clock and the data from it. Every level change on the line, rising or falling, becomes a single-cycle mark. Marks occur at up to twice the bit rate. A numerically controlled oscillator (NCO) runs at that doubled rate. Its accumulator increment is the sum of a nominal value on a port and a bounded proportional-plus-integral correction. The correction is steered by a phase comparator that looks only at marks. A mark arriving before the accumulator wraps speeds the oscillator up. A mark arriving after the wrap slows it down.

Each oscillator period is framed as a window centred on the accumulator wrap. A half-rate flag toggles at every window end, and the recovered clock is the inverse of that flag. A transition preceded by an empty window can only be a mid-bit transition, so such a transition re-aligns the half-rate flag. This is how the alternating preamble locks the bit framing.

At the end of each mid-bit window, the line level gives the bit. When enough consecutive bits have carried a mid-bit transition, the data bit is presented together with a one-cycle strobe. During a silent line the oscillator coasts at its last corrected frequency, and the recovered clock keeps running.

Top module: `splitphase_cdr`

## Requirements
- R1: While and just after reset, `rclk_o`, `data_o` and `valid_o` are all 0.
- R2: A bit whose mid-bit transition is rising decodes as 0, and one whose mid-bit transition is falling decodes as 1. Strobed bits leave in line order.
- R3: The phase comparator issues at most one of speed-up/slow-down in a cycle. It issues one only in the cycle after a transition mark, for marks of either polarity.
- R4: With `nom_inc` (line-rate NCO increment = 2^ACC_W / half-bit clocks) off by up to 2 percent, every payload bit after the preamble decodes correctly.
- R5: The integral correction stays within plus or minus IMAX at all times.
- R6: With no transitions on the line, `rclk_o` keeps running at the last tracked frequency, giving one rising edge per bit period (within one edge over 20 bits).
- R7: `rclk_o` changes only in the cycle after an oscillator window end, and has a period of two oscillator cycles.
- R8: `valid_o` is a one-cycle pulse, at most one per bit. The first PRE_BITS qualified bits of a burst give no strobe. A preamble of PRE_BITS+n bits yields exactly n strobes before the payload.
- R9: A bit period without a mid-bit transition clears the qualification, so a following burst of only PRE_BITS bits gives no strobe.
- R10: `data_o` changes only together with a `valid_o` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| nom_inc | input | ACC_W | Nominal NCO increment per clock (2^ACC_W over half-bit clock count) |
| rx_in | input | 1 | Split-phase serial line, asynchronous |
| rclk_o | output | 1 | Recovered bit clock |
| data_o | output | 1 | Recovered data bit |
| valid_o | output | 1 | One-cycle strobe for `data_o` |

## Verification
A transition mark can fall in the same cycle as an oscillator window end. It must then be counted in the new window and steer the loop by the new accumulator phase. When it is the first transition after silence, it also snaps the accumulator. The bench provokes this by sweeping the nominal increment 2 percent above and below the line rate, so the mark phase drifts across the wrap and window boundaries while the integral converges. It judges the outcome by comparing every strobed bit, in order and in number, against the arithmetic expectation for preamble and payload.

// File: rtl/spcdr_pkg.sv
package spcdr_pkg;
  typedef enum logic [1:0] {
    STEER_HOLD = 2'd0,
    STEER_UP   = 2'd1,
    STEER_DN   = 2'd2
  } steer_e;
endpackage

// File: rtl/spcdr_edge_mark.sv
module spcdr_edge_mark #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic lvl_o,
  output logic mark_o
);
  logic [SYNC_STAGES:0] shr_q;

  always_ff @(posedge clk) begin
    if (rst) shr_q <= '0;
    else     shr_q <= {shr_q[SYNC_STAGES-1:0], rx_in};
  end

  // level after synchronisation; a mark for any change of level
  assign lvl_o  = shr_q[SYNC_STAGES-1];
  assign mark_o = shr_q[SYNC_STAGES-1] ^ shr_q[SYNC_STAGES];
endmodule

// File: rtl/spcdr_phase_cmp.sv
module spcdr_phase_cmp
  import spcdr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   mark,
  input  logic   snap,
  input  logic   acc_msb,
  output steer_e steer_o
);
  // edge-only decision: upper half of the accumulator means the wrap
  // has not come yet (oscillator late), lower half means it came early
  always_ff @(posedge clk) begin
    if (rst) steer_o <= STEER_HOLD;
    else if (mark && !snap) steer_o <= acc_msb ? STEER_UP : STEER_DN;
    else steer_o <= STEER_HOLD;
  end
endmodule

// File: rtl/spcdr_nco.sv
module spcdr_nco
  import spcdr_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int KP    = 2048,
  parameter int KI    = 32,
  parameter int IMAX  = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ACC_W-1:0]         nom_inc,
  input  logic                     snap,
  input  steer_e                   steer,
  output logic                     acc_msb_o,
  output logic                     win_end_o,
  output logic signed [ACC_W+1:0]  integ_o
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] KP_S   = SW'(KP);
  localparam logic signed [SW-1:0] KI_S   = SW'(KI);
  localparam logic signed [SW-1:0] IMAX_S = SW'(IMAX);

  logic [ACC_W-1:0]        acc_q, acc_d, inc_u;
  logic signed [SW-1:0]    integ_q, integ_n, kick, inc_s;
  logic                    win_q;

  always_comb begin
    integ_n = integ_q;
    kick    = '0;
    if (steer == STEER_UP) begin
      kick    = KP_S;
      integ_n = integ_q + KI_S;
      if (integ_n > IMAX_S) integ_n = IMAX_S;
    end else if (steer == STEER_DN) begin
      kick    = -KP_S;
      integ_n = integ_q - KI_S;
      if (integ_n < -IMAX_S) integ_n = -IMAX_S;
    end
    inc_s = $signed({2'b00, nom_inc}) + integ_q + kick;
    // the accumulator never runs backwards
    if (inc_s < 0) inc_u = '0;
    else           inc_u = inc_s[ACC_W-1:0];
    acc_d = snap ? '0 : acc_q + inc_u;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      integ_q <= '0;
      win_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      integ_q <= integ_n;
      win_q   <= !acc_q[ACC_W-1] && acc_d[ACC_W-1];
    end
  end

  assign acc_msb_o = acc_q[ACC_W-1];
  assign win_end_o = win_q;
  assign integ_o   = integ_q;
endmodule

// File: rtl/spcdr_bit_slicer.sv
module spcdr_bit_slicer #(
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mark,
  input  logic lvl,
  input  logic win_end,
  output logic snap_o,
  output logic rclk_o,
  output logic data_o,
  output logic valid_o
);
  localparam int CNT_W = $clog2(PRE_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(PRE_BITS);

  logic             cur_q, prev_q, half_q, rclk_q, data_q, valid_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             lone, half_n;

  always_comb begin
    lone   = cur_q && !prev_q;          // transition after an empty window is mid-bit
    half_n = lone ? 1'b1 : ~half_q;
    cnt_n  = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
  end

  // first transition after silence re-phases the oscillator
  assign snap_o = mark && (cnt_q == '0) && !cur_q && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= 1'b0;
      prev_q  <= 1'b0;
      half_q  <= 1'b0;
      rclk_q  <= 1'b0;
      data_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (win_end) begin
        prev_q <= cur_q;
        cur_q  <= mark;
        half_q <= half_n;
        rclk_q <= ~half_n;
        if (half_n) begin
          if (cur_q) begin
            cnt_q <= cnt_n;
            if (cnt_n > CNT_PRE) begin
              valid_q <= 1'b1;
              data_q  <= ~lvl;          // rising mid-bit -> high level -> 0
            end
          end else begin
            cnt_q <= '0;
          end
        end
      end else begin
        cur_q <= cur_q | mark;
      end
    end
  end

  assign rclk_o  = rclk_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/splitphase_cdr.sv
module splitphase_cdr
  import spcdr_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_BITS    = 8,
  parameter int KP          = 2048,
  parameter int KI          = 32,
  parameter int IMAX        = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] nom_inc,
  input  logic             rx_in,
  output logic             rclk_o,
  output logic             data_o,
  output logic             valid_o
);
  logic                   lvl, mark, snap, acc_msb, win_end;
  steer_e                 steer;
  logic signed [ACC_W+1:0] integ;

  spcdr_edge_mark #(.SYNC_STAGES(SYNC_STAGES)) u_mark (
    .clk(clk), .rst(rst), .rx_in(rx_in), .lvl_o(lvl), .mark_o(mark)
  );

  spcdr_phase_cmp u_pcmp (
    .clk(clk), .rst(rst), .mark(mark), .snap(snap),
    .acc_msb(acc_msb), .steer_o(steer)
  );

  spcdr_nco #(.ACC_W(ACC_W), .KP(KP), .KI(KI), .IMAX(IMAX)) u_nco (
    .clk(clk), .rst(rst), .nom_inc(nom_inc), .snap(snap), .steer(steer),
    .acc_msb_o(acc_msb), .win_end_o(win_end), .integ_o(integ)
  );

  spcdr_bit_slicer #(.PRE_BITS(PRE_BITS)) u_slice (
    .clk(clk), .rst(rst), .mark(mark), .lvl(lvl), .win_end(win_end),
    .snap_o(snap), .rclk_o(rclk_o), .data_o(data_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/splitphase_cdr_chk.sv
module splitphase_cdr_chk
  import spcdr_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int IMAX  = 1024
) (
  input logic                    clk,
  input logic                    rst,
  input steer_e                  steer,
  input logic                    mark,
  input logic signed [ACC_W+1:0] integ,
  input logic                    win_end,
  input logic                    rclk,
  input logic                    data,
  input logic                    valid
);
  localparam logic signed [ACC_W+1:0] LIM = (ACC_W+2)'(IMAX);

  AST_STEER_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (steer == STEER_HOLD || steer == STEER_UP || steer == STEER_DN)); // R3
  AST_STEER_FROM_MARK: assert property (@(posedge clk) disable iff (rst)
    (steer != STEER_HOLD) |-> $past(mark)); // R3
  AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (rst)
    (integ <= LIM && integ >= -LIM)); // R5
  AST_RCLK_AT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (rclk != $past(rclk)) |-> $past(win_end)); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(data)); // R10
endmodule

bind splitphase_cdr splitphase_cdr_chk #(.ACC_W(ACC_W), .IMAX(IMAX)) u_chk (
  .clk(clk), .rst(rst), .steer(steer), .mark(mark), .integ(integ),
  .win_end(win_end), .rclk(rclk_o), .data(data_o), .valid(valid_o)
);

// File: tb/tb_splitphase_cdr.sv
module tb_splitphase_cdr;
  localparam int ACC_W = 16;
  localparam int PRE   = 8;
  localparam int HALF  = 16;              // clocks per half bit
  localparam int BITC  = 2 * HALF;
  localparam int NOM   = 4096;            // 2^16 / HALF
  localparam int PREAMBLE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ACC_W-1:0] nom_inc = ACC_W'(NOM);
  logic rx_in = 1'b0;
  logic rclk_o, data_o, valid_o;

  int total = 0;
  int fails = 0;
  int nrec  = 0;
  int rises = 0;
  logic rclk_prev = 1'b0;
  logic rec [0:127];

  always #10 clk = ~clk;

  splitphase_cdr #(.ACC_W(ACC_W), .PRE_BITS(PRE)) dut (
    .clk(clk), .rst(rst), .nom_inc(nom_inc), .rx_in(rx_in),
    .rclk_o(rclk_o), .data_o(data_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (!rst && valid_o && nrec < 128) begin
      rec[nrec] = data_o;
      nrec++;
    end
    if (!rst && rclk_o && !rclk_prev) rises++;
    rclk_prev = rclk_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    nrec = 0;
  endtask

  task automatic send_bit(input logic b);
    rx_in = b;                 // 1: high then low (falling mid); 0: low then high
    repeat (HALF) @(negedge clk);
    rx_in = ~b;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rx_in = 1'b0;
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic run(input int nom, input logic [23:0] pay);
    int r0, n0;
    nom_inc = ACC_W'(nom);
    do_reset();
    repeat (40) @(negedge clk);
    for (int i = 0; i < PREAMBLE; i++) send_bit(1'(i % 2));
    for (int i = 0; i < 24; i++) send_bit(pay[i]);
    idle_bits(2);
    // R8: preamble beyond PRE bits plus payload strobed, nothing more
    check(nrec == PREAMBLE - PRE + 24, "R8 strobe count", nrec, PREAMBLE - PRE + 24);
    for (int j = 0; j < PREAMBLE - PRE + 24 && j < nrec; j++) begin
      int e;
      e = (j < PREAMBLE - PRE) ? (j % 2) : int'(pay[j - (PREAMBLE - PRE)]);
      check(rec[j] == 1'(e), "R2/R4 decoded bit", int'(rec[j]), e);
    end
    // R6: coasting clock; R9: no strobes in silence
    r0 = rises;
    n0 = nrec;
    idle_bits(20);
    check((rises - r0) >= 19 && (rises - r0) <= 21, "R6 coast edges", rises - r0, 20);
    check(nrec == n0, "R9 silent strobes", nrec - n0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check(rclk_o == 1'b0, "R1 rclk", int'(rclk_o), 0);
    check(data_o == 1'b0, "R1 data", int'(data_o), 0);
    check(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);

    // R8: exactly PRE bits -> no strobe; PRE+1 bits -> one strobe of bit index PRE
    repeat (40) @(negedge clk);
    for (int i = 0; i < PRE; i++) send_bit(1'(i % 2));
    idle_bits(3);
    check(nrec == 0, "R8 short preamble", nrec, 0);
    for (int i = 0; i < PRE + 1; i++) send_bit(1'(i % 2));
    idle_bits(3);
    check(nrec == 1, "R8 one past preamble", nrec, 1);
    check(rec[0] == 1'((PRE) % 2), "R2 first strobed bit", int'(rec[0]), PRE % 2);
    // R9: qualification cleared by the silence above
    for (int i = 0; i < PRE; i++) send_bit(1'(i % 2));
    idle_bits(3);
    check(nrec == 1, "R9 requalify", nrec, 1);

    // R4/R3/R7 sweep: nominal rate and +-2 percent, several payloads
    for (int f = 0; f < 3; f++) begin
      int nom;
      nom = (f == 0) ? NOM : (f == 1) ? (NOM * 98) / 100 : (NOM * 102) / 100;
      run(nom, 24'h000000);
      run(nom, 24'hFFFFFF);
      run(nom, 24'hAAAAAA);
      run(nom, 24'h5A3C96);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule